// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block collects single-cycle event strobes from a group of timer/counters (wrap-around overflows, compare matches and an input capture), latches each into a sticky status flag, and turns the flags into interrupt requests for a processor. A processor-side register port writes and reads two 8-bit registers: the status flags and an enable mask with the same bit layout. A global interrupt-enable input gates all requests. The block drives one request line per source and a registered index of the highest-priority pending source.

Each flag has two ways to be cleared. Software writes a one to the flag's bit, or the processor acknowledges the vector of that source. A flag may also take its set strobe from another place. For a source marked by a parameter, a per-bit mode input switches the set source from the top wrap-around strobe to the bottom turnaround strobe of a counter that counts up and down. With the default parameters this applies to the timer-0 overflow flag.

Top module: `timer_irq_flags`

## Requirements
- R1: While reset is high and in the first cycle after it, the flag register, the mask register, `irq_o`, `pend_valid_o`, `pend_idx_o` and `rd_data_o` are all zero.
- R2: An event strobe on `evt_i[k]` sets flag bit k at the next clock edge. The bit positions are: 7 timer-1 overflow, 6 timer-1 compare A, 5 timer-1 compare B, 4 timer-2 compare, 3 timer-1 capture, 2 timer-2 overflow, 1 timer-0 overflow, 0 timer-0 compare.
- R3: For a bit k enabled in `ALT_SRC_MASK` (default: bit 1 only), the following applies. When `pc_mode_i[k]` is 1, flag k is set by `turn_i[k]` and `evt_i[k]` is ignored. When `pc_mode_i[k]` is 0, `turn_i[k]` is ignored. For every other bit, `turn_i` and `pc_mode_i` have no effect.
- R4: A write with `wr_sel_i`=0 (flag register) clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: When `ack_valid_i` is high, the flag at index `ack_idx_i` is cleared at that clock edge. All other flags are unaffected.
- R6: If a set strobe and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R7: A write with `wr_sel_i`=1 loads the mask register with `wr_data_i`. Without such a write the mask holds. `rd_data_o` shows one clock later the flag register (`rd_sel_i`=0) or the mask (`rd_sel_i`=1) as they were before that edge.
- R8: One clock after the state is present, `irq_o[k]` is 1 exactly when `gie_i`, mask bit k and flag bit k are all 1.
- R9: `pend_valid_o` is 1 exactly when some bit of `irq_o` is 1. `pend_idx_o` is then the highest active index (bit 7 has the highest priority). It is 0 when no request is active.
- R10: Flags are set by their events regardless of the mask and of `gie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N | Primary set strobes, one per flag |
| turn_i | input | N | Bottom-turnaround set strobes (alternate source) |
| pc_mode_i | input | N | Per-bit select of the alternate set source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 flags, 1 mask |
| wr_data_i | input | N | Write data (write-one-to-clear for flags) |
| rd_sel_i | input | 1 | Read source: 0 flags, 1 mask |
| rd_data_o | output | N | Registered read data |
| gie_i | input | 1 | Global interrupt enable |
| ack_valid_i | input | 1 | Vector acknowledge strobe |
| ack_idx_i | input | IDX_W | Index of the acknowledged source |
| irq_o | output | N | Registered per-source interrupt requests |
| pend_valid_o | output | 1 | Some request is active |
| pend_idx_o | output | IDX_W | Highest-priority active source |

## Verification
The bench builds the block with its default parameters: N=8 and only the timer-0 overflow bit having an alternate source. With these values every one of the 256 flag patterns and every mask value can be swept. The sweep covers all write-one-to-clear data patterns and every acknowledge index. It also covers the priority encoder over all 256 request patterns under several masks, with the global enable both on and off. The single alternate-source bit lets the bench check both the selected and the ignored strobe in each mode. It can also confirm that mode bits on other positions change nothing.

// File: rtl/timer_irq_pkg.sv
package timer_irq_pkg;

  localparam int DEF_SRC_N = 8;

  typedef enum logic {
    SEL_FLAG = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/timer_irq_set_sel.sv
module timer_irq_set_sel #(
  parameter int          N            = 8,
  parameter logic [N-1:0] ALT_SRC_MASK = 8'h02
) (
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] turn_i,
  input  logic [N-1:0] pc_mode_i,
  output logic [N-1:0] set_o
);

  for (genvar k = 0; k < N; k++) begin : g_src
    if (ALT_SRC_MASK[k]) begin : g_alt
      assign set_o[k] = pc_mode_i[k] ? turn_i[k] : evt_i[k];
    end else begin : g_fixed
      logic unused_alt;
      assign unused_alt = turn_i[k] ^ pc_mode_i[k];
      assign set_o[k]   = evt_i[k] | (unused_alt & 1'b0);
    end
  end

endmodule

// File: rtl/timer_irq_flag_bank.sv
module timer_irq_flag_bank
  import timer_irq_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     set_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [N-1:0]     wr_data_i,
  input  logic             rd_sel_i,
  input  logic             ack_valid_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic [N-1:0]     flag_o,
  output logic [N-1:0]     mask_o,
  output logic [N-1:0]     rd_data_o
);

  reg_sel_e       wsel, rsel;
  logic [N-1:0]   flag_q, mask_q, rd_q;
  logic [N-1:0]   wr_clr, ack_clr;

  assign wsel = reg_sel_e'(wr_sel_i);
  assign rsel = reg_sel_e'(rd_sel_i);

  always_comb begin
    wr_clr  = (wr_en_i && wsel == SEL_FLAG) ? wr_data_i : '0;
    ack_clr = '0;
    if (ack_valid_i) ack_clr[ack_idx_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      mask_q <= '0;
      rd_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~(wr_clr | ack_clr)) | set_i;
      if (wr_en_i && wsel == SEL_MASK) mask_q <= wr_data_i;
      rd_q <= (rsel == SEL_MASK) ? mask_q : flag_q;
    end
  end

  assign flag_o    = flag_q;
  assign mask_o    = mask_q;
  assign rd_data_o = rd_q;

endmodule

// File: rtl/timer_irq_prio.sv
module timer_irq_prio #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gie_i,
  input  logic [N-1:0]     flag_i,
  input  logic [N-1:0]     mask_i,
  output logic [N-1:0]     irq_o,
  output logic             pend_valid_o,
  output logic [IDX_W-1:0] pend_idx_o
);

  logic [N-1:0]     req;
  logic [IDX_W-1:0] win;
  logic             any;

  assign req = {N{gie_i}} & mask_i & flag_i;

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (req[k]) begin
        win = IDX_W'(k);
        any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o        <= '0;
      pend_valid_o <= 1'b0;
      pend_idx_o   <= '0;
    end else begin
      irq_o        <= req;
      pend_valid_o <= any;
      pend_idx_o   <= win;
    end
  end

endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags #(
  parameter int           N            = 8,
  parameter logic [N-1:0] ALT_SRC_MASK = 8'h02,
  localparam int          IDX_W        = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     evt_i,
  input  logic [N-1:0]     turn_i,
  input  logic [N-1:0]     pc_mode_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [N-1:0]     wr_data_i,
  input  logic             rd_sel_i,
  output logic [N-1:0]     rd_data_o,
  input  logic             gie_i,
  input  logic             ack_valid_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic [N-1:0]     irq_o,
  output logic             pend_valid_o,
  output logic [IDX_W-1:0] pend_idx_o
);

  logic [N-1:0] set_vec;
  logic [N-1:0] flag_q;
  logic [N-1:0] mask_q;

  timer_irq_set_sel #(.N(N), .ALT_SRC_MASK(ALT_SRC_MASK)) set_sel_i (
    .evt_i     (evt_i),
    .turn_i    (turn_i),
    .pc_mode_i (pc_mode_i),
    .set_o     (set_vec)
  );

  timer_irq_flag_bank #(.N(N), .IDX_W(IDX_W)) bank_i (
    .clk         (clk),
    .rst         (rst),
    .set_i       (set_vec),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .rd_sel_i    (rd_sel_i),
    .ack_valid_i (ack_valid_i),
    .ack_idx_i   (ack_idx_i),
    .flag_o      (flag_q),
    .mask_o      (mask_q),
    .rd_data_o   (rd_data_o)
  );

  timer_irq_prio #(.N(N), .IDX_W(IDX_W)) prio_i (
    .clk          (clk),
    .rst          (rst),
    .gie_i        (gie_i),
    .flag_i       (flag_q),
    .mask_i       (mask_q),
    .irq_o        (irq_o),
    .pend_valid_o (pend_valid_o),
    .pend_idx_o   (pend_idx_o)
  );

endmodule

// File: rtl/timer_irq_flags_chk.sv
module timer_irq_flags_chk #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [N-1:0]     wr_data_i,
  input logic             ack_valid_i,
  input logic [IDX_W-1:0] ack_idx_i,
  input logic [N-1:0]     set_vec,
  input logic [N-1:0]     flag_q,
  input logic [N-1:0]     mask_q,
  input logic [N-1:0]     irq_o,
  input logic             pend_valid_o,
  input logic [IDX_W-1:0] pend_idx_o
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (flag_q == '0 && mask_q == '0 && irq_o == '0 && !pend_valid_o));

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !wr_sel_i) |=> ((flag_q & $past(wr_data_i & ~set_vec)) == '0));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid_i && !set_vec[ack_idx_i]) |=> !flag_q[$past(ack_idx_i)]);

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && wr_sel_i) |=> $stable(mask_q));

  // R9
  pend_any_chk: assert property (@(posedge clk) disable iff (rst)
    pend_valid_o == (|irq_o));

  // R9
  pend_top_chk: assert property (@(posedge clk) disable iff (rst)
    pend_valid_o |-> ((irq_o >> pend_idx_o) == {{(N-1){1'b0}}, 1'b1}));

endmodule

bind timer_irq_flags timer_irq_flags_chk #(.N(N), .IDX_W(IDX_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .ack_valid_i  (ack_valid_i),
  .ack_idx_i    (ack_idx_i),
  .set_vec      (set_vec),
  .flag_q       (flag_q),
  .mask_q       (mask_q),
  .irq_o        (irq_o),
  .pend_valid_o (pend_valid_o),
  .pend_idx_o   (pend_idx_o)
);

// File: tb/timer_irq_flags_tb_top.sv
module timer_irq_flags_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] evt, turn, pcm, wr_data, rd_data, irq;
  logic       wr_en, wr_sel, rd_sel, gie, ack_v, pv;
  logic [2:0] ack_idx, pidx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] m_flag, m_mask, e_irq, e_rd;
  logic       e_pv;
  logic [2:0] e_pidx;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_irq_flags dut_i (
    .clk(clk), .rst(rst), .evt_i(evt), .turn_i(turn), .pc_mode_i(pcm),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .gie_i(gie), .ack_valid_i(ack_v), .ack_idx_i(ack_idx),
    .irq_o(irq), .pend_valid_o(pv), .pend_idx_o(pidx)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic check_out(string r);
    chk({r, " rd"}, 32'(rd_data), 32'(e_rd));
    chk({r, " irq"}, 32'(irq), 32'(e_irq));
    chk({r, " pv"}, 32'(pv), 32'(e_pv));
    chk({r, " pidx"}, 32'(pidx), 32'(e_pidx));
  endtask

  // Model advances with the inputs applied now, then one clock passes.
  task automatic tick();
    logic [7:0] setv, clr, req;
    if (rst) begin
      m_flag = '0; m_mask = '0; e_irq = '0; e_pv = 0; e_pidx = '0; e_rd = '0;
    end else begin
      req    = {8{gie}} & m_mask & m_flag;
      e_irq  = req;
      e_pv   = |req;
      e_pidx = '0;
      for (int k = 0; k < 8; k++) if (req[k]) e_pidx = 3'(k);
      e_rd   = rd_sel ? m_mask : m_flag;
      setv   = evt;
      if (pcm[1]) setv[1] = turn[1];
      clr = (wr_en && !wr_sel) ? wr_data : 8'h00;
      if (ack_v) clr[ack_idx] = 1'b1;
      m_flag = (m_flag & ~clr) | setv;
      if (wr_en && wr_sel) m_mask = wr_data;
    end
    @(negedge clk);
    evt = '0; turn = '0; wr_en = 0; ack_v = 0;
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
  endtask

  task automatic read_reg(logic sel, string r, logic [7:0] exp);
    rd_sel = sel;
    tick();
    chk(r, 32'(rd_data), 32'(exp));
    chk({r, " model"}, 32'(rd_data), 32'(e_rd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; evt = 0; turn = 0; pcm = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    rd_sel = 0; gie = 0; ack_v = 0; ack_idx = 0;
    @(negedge clk);
    repeat (3) tick();
    check_out("R1 in reset");
    rst = 0;
    tick();
    check_out("R1 after reset");

    // R7: every mask value round-trips through the read port
    for (int v = 0; v < 256; v++) begin
      wr(1, 8'(v)); tick();
      read_reg(1, "R7 mask readback", 8'(v));
    end
    wr(1, 8'h00); tick();

    // R2 / R10: each event sets only its own bit, mask and gie off
    for (int k = 0; k < 8; k++) begin
      wr(0, 8'hFF); tick();
      evt = 8'(1 << k); tick();
      read_reg(0, "R2 single event", 8'(1 << k));
      chk("R10 no irq while masked", 32'(irq), 32'h0);
    end

    // R4: write-one-to-clear over every data pattern
    for (int p = 0; p < 256; p++) begin
      evt = 8'hFF; tick();
      wr(0, 8'(p)); tick();
      read_reg(0, "R4 w1c", ~8'(p));
    end

    // R5: acknowledge clears exactly the indexed flag
    for (int k = 0; k < 8; k++) begin
      evt = 8'hFF; tick();
      ack_v = 1; ack_idx = 3'(k); tick();
      read_reg(0, "R5 ack", 8'hFF & ~8'(1 << k));
    end

    // R6: set beats write-one-clear and acknowledge
    for (int k = 0; k < 8; k++) begin
      evt = 8'hFF; tick();
      wr(0, 8'hFF); evt = 8'(1 << k); tick();
      read_reg(0, "R6 set vs w1c", 8'(1 << k));
      ack_v = 1; ack_idx = 3'(k); evt = 8'(1 << k); tick();
      read_reg(0, "R6 set vs ack", 8'(1 << k));
    end

    // R3: alternate set source on the timer-0 overflow bit
    wr(0, 8'hFF); tick();
    pcm = 8'h02; evt = 8'h02; tick();
    read_reg(0, "R3 wrap ignored in pc mode", 8'h00);
    turn = 8'h02; tick();
    read_reg(0, "R3 turn sets in pc mode", 8'h02);
    wr(0, 8'hFF); tick();
    pcm = 8'h00; turn = 8'hFF; tick();
    read_reg(0, "R3 turn ignored in normal mode", 8'h00);
    pcm = 8'hFF; turn = 8'hFF; tick();
    read_reg(0, "R3 turn only on alt bit", 8'h02);
    wr(0, 8'hFF); tick();
    pcm = 8'hFF; evt = 8'hFF; tick();
    read_reg(0, "R3 other bits keep primary source", 8'hFD);
    pcm = 8'h00;

    // R8 / R9: request gating and priority over all flag patterns
    for (int g = 0; g < 2; g++) begin
      for (int mi = 0; mi < 4; mi++) begin
        for (int f = 0; f < 256; f++) begin
          logic [7:0] m, er;
          logic [2:0] ei;
          m = (mi == 0) ? 8'hFF : (mi == 1) ? 8'h5A : (mi == 2) ? 8'h81 : 8'h0F;
          wr(0, 8'hFF); evt = 8'(f); tick();
          wr(1, m); gie = g[0]; tick();
          tick();
          er = g[0] ? (8'(f) & m) : 8'h00;
          ei = '0;
          for (int k = 0; k < 8; k++) if (er[k]) ei = 3'(k);
          chk("R8 irq gating", 32'(irq), 32'(er));
          chk("R9 pend valid", 32'(pv), 32'(|er));
          chk("R9 pend index", 32'(pidx), 32'(ei));
          check_out("R8 R9 model");
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule